// File: doc/BRIEF.md
# Bus Cycle Sequencer with Wait-State Insertion

This block is the processor-side controller for one memory or I/O transfer. A transfer starts on a request and then passes through four clock states: address phase (T1), command phase (T2), data phase (T3) and release phase (T4). Between T2 and T3 it adds as many whole-period wait states (TW) as a slow target asks for by holding the READY line low. Each wait adds exactly one clock period. At a 200 ns clock, a 460 ns access becomes 660 ns with one wait.

READY is not looked at on the same edge in every state. At the end of T2 it is captured on the falling clock edge, in the middle of the period. That captured value is held in a flag until the rising edge that moves the state register. Inside TW, the level present at the rising edge that closes the period decides whether another wait follows. The block drives active-low read and write strobes, an address-latch strobe and a one-cycle completion pulse. All outputs come straight from flip-flops. After T4 it rests in an idle state until the next request.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is asserted (rst_n low), bus_state is 0 (idle), rd_n and wr_n are 1, and ale and done are 0.
- R2: In idle, start_req high at a rising edge moves bus_state to 1 (T1) on that edge. Without it, the block stays idle. start_req has no effect in any other state.
- R3: T1 is followed by T2 (code 2) unconditionally, and ale is 1 exactly while bus_state is 1.
- R4: Leaving T2, the next state is TW (code 3) when READY was low at the falling edge inside T2, and T3 (code 4) when it was high. The READY level at the rising edge that ends T2 does not matter.
- R5: In TW, READY high at the closing rising edge gives T3, and READY low gives another TW. There is no limit on the number of consecutive waits.
- R6: T3 is followed by T4 (code 5), and T4 is followed by idle.
- R7: For a read (wr_sel 0 at start), rd_n is low exactly in T2, TW and T3. For a write (wr_sel 1), wr_n is low in those same states. The two strobes are never low together.
- R8: done is 1 exactly while bus_state is 5 (T4), one cycle per transfer.
- R9: The direction is taken from wr_sel at the accepting edge in idle. Later changes of wr_sel during the transfer do not change which strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state moves on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | 1 | Request a new transfer |
| wr_sel | input | 1 | Direction of the requested transfer: 1 write, 0 read |
| ready | input | 1 | Target ready; low asks for wait states |
| bus_state | output | 3 | Current clock state: 0 idle, 1 T1, 2 T2, 3 TW, 4 T3, 5 T4 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ale | output | 1 | Address-latch strobe, high in T1 |
| done | output | 1 | Transfer-complete pulse in T4 |

## Verification
The sharpest corner case is a READY line that differs between the falling edge inside T2 and the following rising edge. A design that samples the rising edge at T2 would skip a wait it owes, or add one it does not. Long runs of waits show up any counter that saturates or any exit that is forced. Requests that arrive mid-transfer, and direction flips during a transfer, catch a design that restarts or that swaps strobes. Random READY patterns compared each cycle against a bench reference model find strobes that lag or lead the state by a cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        BS_IDLE = 3'd0,
        BS_T1   = 3'd1,
        BS_T2   = 3'd2,
        BS_TW   = 3'd3,
        BS_T3   = 3'd4,
        BS_T4   = 3'd5
    } bstate_e;

    typedef struct packed {
        bstate_e st;
        logic    is_wr;
        logic    rd_n;
        logic    wr_n;
        logic    ale;
        logic    done;
    } seq_regs_t;
endpackage

// File: rtl/bcs_wait_latch.sv
module bcs_wait_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic in_t2,
    input  logic ready,
    output logic wait_req
);
    logic wait_d, wait_q;

    // Falling-edge capture of READY while the command phase is active.
    always_comb begin
        wait_d = 1'b0;
        if (in_t2) wait_d = ~ready;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) wait_q <= 1'b0;
        else        wait_q <= wait_d;
    end

    assign wait_req = wait_q;
endmodule

// File: rtl/bcs_seq_ctrl.sv
module bcs_seq_ctrl
    import bcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_req,
    input  logic    wr_sel,
    input  logic    ready,
    input  logic    t2_wait,
    output bstate_e st,
    output logic    rd_n,
    output logic    wr_n,
    output logic    ale,
    output logic    done
);
    seq_regs_t r_d, r_q;
    logic      strobe_on;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            BS_IDLE: if (start_req) begin
                         r_d.st    = BS_T1;
                         r_d.is_wr = wr_sel;
                     end
            BS_T1:   r_d.st = BS_T2;
            BS_T2:   r_d.st = t2_wait ? BS_TW : BS_T3;
            BS_TW:   r_d.st = ready ? BS_T3 : BS_TW;
            BS_T3:   r_d.st = BS_T4;
            BS_T4:   r_d.st = BS_IDLE;
            default: r_d.st = BS_IDLE;
        endcase
        strobe_on = (r_d.st == BS_T2) || (r_d.st == BS_TW) || (r_d.st == BS_T3);
        r_d.rd_n  = ~(strobe_on & ~r_d.is_wr);
        r_d.wr_n  = ~(strobe_on &  r_d.is_wr);
        r_d.ale   = (r_d.st == BS_T1);
        r_d.done  = (r_d.st == BS_T4);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= BS_IDLE;
            r_q.is_wr <= 1'b0;
            r_q.rd_n  <= 1'b1;
            r_q.wr_n  <= 1'b1;
            r_q.ale   <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign st   = r_q.st;
    assign rd_n = r_q.rd_n;
    assign wr_n = r_q.wr_n;
    assign ale  = r_q.ale;
    assign done = r_q.done;

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == BS_IDLE && start_req) |=> (r_q.st == BS_T1));
    p_t1_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == BS_T1) |=> (r_q.st == BS_T2));
    p_ale_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ale |-> (r_q.st == BS_T1));
    p_tw_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == BS_TW && ready) |=> (r_q.st == BS_T3));
    p_tw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == BS_TW && !ready) |=> (r_q.st == BS_TW));
    p_t3_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == BS_T3) |=> (r_q.st == BS_T4));
    p_t4_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == BS_T4) |=> (r_q.st == BS_IDLE));
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!r_q.rd_n && !r_q.wr_n));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);
    p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != BS_IDLE && r_q.st != BS_T1) |-> $stable(r_q.is_wr));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic               wr_sel,
    input  logic               ready,
    output logic [STATE_W-1:0] bus_state,
    output logic               rd_n,
    output logic               wr_n,
    output logic               ale,
    output logic               done
);
    bstate_e st;
    logic    t2_wait;

    bcs_wait_latch u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_t2    (st == BS_T2),
        .ready    (ready),
        .wait_req (t2_wait)
    );

    bcs_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .wr_sel    (wr_sel),
        .ready     (ready),
        .t2_wait   (t2_wait),
        .st        (st),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ale       (ale),
        .done      (done)
    );

    assign bus_state = st;

    p_t2_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BS_T2 && t2_wait) |=> (st == BS_TW));
    p_t2_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BS_T2 && !t2_wait) |=> (st == BS_T3));
endmodule

// File: tb/sim_bus_cycle_seq.sv
`timescale 1ns/1ps
module sim_bus_cycle_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic       wr_sel = 1'b0;
    logic       ready = 1'b1;
    logic [2:0] bus_state;
    logic       rd_n, wr_n, ale, done;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 0;
    int  m_state = 0;
    bit  m_wr = 0;

    always #2.5 clk = ~clk;

    bus_cycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .wr_sel(wr_sel),
        .ready(ready), .bus_state(bus_state), .rd_n(rd_n), .wr_n(wr_n),
        .ale(ale), .done(done)
    );

    function automatic int next_state(int s, bit st, bit rn, bit rp);
        case (s)
            0: return st ? 1 : 0;      // R2
            1: return 2;               // R3
            2: return rn ? 4 : 3;      // R4
            3: return rp ? 4 : 3;      // R5
            4: return 5;               // R6
            default: return 0;         // R6
        endcase
    endfunction

    function automatic bit exp_active(int s);
        return (s == 2) || (s == 3) || (s == 4);
    endfunction

    task automatic check_all(string tag);
        bit e_rd, e_wr, e_ale, e_done;
        e_rd   = !(exp_active(m_state) && !m_wr);
        e_wr   = !(exp_active(m_state) && m_wr);
        e_ale  = (m_state == 1);
        e_done = (m_state == 5);
        n_vec++;
        if (int'(bus_state) != m_state || rd_n != e_rd || wr_n != e_wr ||
            ale != e_ale || done != e_done) begin
            n_bad++;
            $display("FAIL %s: state/rd_n/wr_n/ale/done got %0d/%b/%b/%b/%b exp %0d/%b/%b/%b/%b",
                     tag, bus_state, rd_n, wr_n, ale, done,
                     m_state, e_rd, e_wr, e_ale, e_done);
        end
    endtask

    function automatic string tag_for(int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R6 R8";
        endcase
    endfunction

    // Called at posedge+1: drive, swap READY after the falling edge, clock, check.
    task automatic cycle(bit st, bit wr, bit rn, bit rp);
        int prev;
        start_req = st;
        wr_sel    = wr;
        ready     = rn;
        #2.5;
        ready     = rp;
        @(posedge clk);
        prev = m_state;
        if (m_state == 0 && st) m_wr = wr;   // R9 direction taken at acceptance
        m_state = next_state(m_state, st, rn, rp);
        #1;
        check_all({tag_for(prev), " R7 R9"});
    endtask

    task automatic run_transfer(bit wr, int waits, bit t2_rp);
        cycle(1, wr, 1, 1);                  // idle -> T1
        cycle(1, ~wr, 1, 1);                 // T1 -> T2, start ignored (R2)
        if (waits == 0) cycle(0, ~wr, 1, t2_rp);
        else            cycle(0, ~wr, 0, t2_rp);
        for (int i = 1; i < waits; i++) cycle(1, wr, 0, 0);   // R5 hold
        if (waits > 0) cycle(0, wr, 0, 1);   // R5 exit
        cycle(1, ~wr, 1, 1);                 // T3 -> T4
        cycle(0, wr, 1, 1);                  // T4 -> idle
    endtask

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: R1 got hung exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        m_state = 0; m_wr = 0;
        check_all("R1");
        start_req = 1'b1;                    // request during reset must not act
        @(posedge clk); #1;
        check_all("R1");
        start_req = 1'b0;
        rst_n = 1'b1;

        cycle(0, 0, 1, 1);                   // stays idle without request (R2)
        run_transfer(0, 0, 1);               // read, no waits
        run_transfer(1, 0, 0);               // R4: ready low only at rising edge ending T2 -> no wait
        run_transfer(0, 1, 1);               // R4: low at falling edge, high at rising -> one wait
        run_transfer(1, 3, 0);
        run_transfer(0, 25, 0);              // long wait run (R5)

        for (int k = 0; k < 4000; k++) begin
            bit st, wr, rn, rp;
            st = ($urandom % 3) != 0;
            wr = $urandom % 2;
            rn = ($urandom % 3) != 0;
            rp = ($urandom % 4) != 0;
            cycle(st, wr, rn, rp);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule